// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when an out-of-order core leaves normal execution for speculative runahead, and how it returns. It watches the oldest entry of the reorder window. When that entry is a long-latency cache miss, the block saves the architectural register map, the branch history register and the return address stack. It also saves the program counter and the miss tag of the blocking instruction. It then removes that instruction from the window, so retirement keeps moving.

While runahead is active, architectural updates are held off. Any long-latency miss that reaches the window head, or an instruction that depends on one, is retired as bogus instead of stalling the window.

Runahead ends only when the miss completion carries the saved tag. The block then spends one cycle flushing the pipeline and presenting the saved state for restore. In the next cycle it redirects fetch to the saved program counter. The pipeline, the caches and the predictors are outside this block.

Top module: `ra_mode_ctrl`

## Requirements
- R1: In normal mode, a cycle with `head_valid` and `head_long_miss` both high raises `ckpt_save` in that same cycle, and `spec_mode` is high from the next cycle. With `head_valid` low, `head_long_miss` has no effect.
- R2: The values on `cur_map`, `cur_bhr` and `cur_ras` in the entry cycle appear on `restore_map`, `restore_bhr` and `restore_ras` during the restore cycle, whatever those inputs do in between.
- R3: The `head_pc` of the entry cycle appears on `redirect_pc` while `redirect_valid` is high.
- R4: In the entry cycle, `bogus_retire` is high, so the blocking instruction leaves the window.
- R5: `spec_mode`, which blocks architectural updates at retirement, stays high from the cycle after entry through the restore cycle.
- R6: While runahead is active, a head entry with `head_valid` and `head_long_miss` high raises `bogus_retire` in that cycle and does not raise `ckpt_save`.
- R7: Runahead ends only on a cycle with `fill_valid` high and `fill_tag` equal to the `head_tag` of the entry cycle. A completion with any other tag, or any completion in normal mode, has no effect on `spec_mode`.
- R8: After the matching completion cycle, `flush` and `restore_valid` are high for exactly one cycle. In the cycle after that, `redirect_valid` is high for one cycle, with `flush` low and `spec_mode` low.
- R9: A new long-latency head during runahead or during the restore cycle does not start a new entry. The saved program counter, tag and state are kept.
- R10: After reset, `spec_mode`, `ckpt_save`, `flush`, `restore_valid`, `redirect_valid` and `bogus_retire` are low, for as long as no head miss is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid | input | 1 | Window head holds an instruction |
| head_long_miss | input | 1 | Head instruction is a long-latency miss or depends on one |
| head_pc | input | PC_W | Program counter of the head instruction |
| head_tag | input | TAG_W | Miss tag of the head instruction |
| cur_map | input | AREGS*PREG_W | Current architectural register map |
| cur_bhr | input | BHR_W | Current branch history register |
| cur_ras | input | RAS_DEPTH*PC_W | Current return address stack contents |
| fill_valid | input | 1 | A miss completion is reported |
| fill_tag | input | TAG_W | Tag of the completing miss |
| ckpt_save | output | 1 | Checkpoint strobe, high in the entry cycle |
| bogus_retire | output | 1 | Retire the head as bogus, without an architectural update |
| spec_mode | output | 1 | Runahead active; architectural updates are blocked |
| flush | output | 1 | Pipeline flush, one cycle |
| restore_valid | output | 1 | Restore strobe for the saved state |
| restore_map | output | AREGS*PREG_W | Saved register map |
| restore_bhr | output | BHR_W | Saved branch history |
| restore_ras | output | RAS_DEPTH*PC_W | Saved return address stack |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | PC_W | Fetch restart address |

## Verification
Two pairs of events can land in the same cycle. The matching completion can coincide with a bogus retire of a dependent miss at the head. A fresh long miss at the head can coincide with the restore cycle. The bench provokes the first pair on every odd episode. It checks that `bogus_retire` still fires in that cycle and that the flush follows exactly one cycle later. It provokes the second pair in every episode. It judges it by `ckpt_save` staying low, and by the redirect address and restored state still matching the values saved at the original entry.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic [1:0] {
    RA_NORMAL  = 2'd0,
    RA_SPEC    = 2'd1,
    RA_RESTORE = 2'd2
  } ra_state_e;
endpackage

// File: rtl/ra_hold_reg.sv
module ra_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load) q <= d;
  end
endmodule

// File: rtl/ra_fsm.sv
module ra_fsm
  import ra_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_valid,
  input  logic             head_long_miss,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [TAG_W-1:0] held_tag,
  output logic             enter_o,
  output logic             bogus_o,
  output logic             spec_o,
  output logic             flush_o,
  output logic             restore_o,
  output logic             redirect_o
);
  ra_state_e state_q, state_d;
  logic      redirect_q;
  logic      head_miss;
  logic      tag_hit;

  assign head_miss = head_valid && head_long_miss;
  assign tag_hit   = fill_valid && (fill_tag == held_tag);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RA_NORMAL:  if (head_miss) state_d = RA_SPEC;
      RA_SPEC:    if (tag_hit)   state_d = RA_RESTORE;
      RA_RESTORE: state_d = RA_NORMAL;
      default:    state_d = RA_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RA_NORMAL;
      redirect_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      redirect_q <= (state_q == RA_RESTORE);
    end
  end

  assign enter_o    = (state_q == RA_NORMAL) && head_miss;
  assign bogus_o    = ((state_q == RA_NORMAL) || (state_q == RA_SPEC)) && head_miss;
  assign spec_o     = (state_q != RA_NORMAL);
  assign flush_o    = (state_q == RA_RESTORE);
  assign restore_o  = (state_q == RA_RESTORE);
  assign redirect_o = redirect_q;

  assert_entry_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spec_o) |-> $past(head_valid && head_long_miss));
  assert_exit_on_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RA_RESTORE) |-> $past(fill_valid && (fill_tag == held_tag)));
  assert_flush_then_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (!flush_o && redirect_o && !spec_o));
endmodule

// File: rtl/ra_mode_ctrl.sv
module ra_mode_ctrl #(
  parameter int AREGS     = 8,
  parameter int PREG_W    = 5,
  parameter int BHR_W     = 12,
  parameter int RAS_DEPTH = 4,
  parameter int PC_W      = 16,
  parameter int TAG_W     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      head_valid,
  input  logic                      head_long_miss,
  input  logic [PC_W-1:0]           head_pc,
  input  logic [TAG_W-1:0]          head_tag,
  input  logic [AREGS*PREG_W-1:0]   cur_map,
  input  logic [BHR_W-1:0]          cur_bhr,
  input  logic [RAS_DEPTH*PC_W-1:0] cur_ras,
  input  logic                      fill_valid,
  input  logic [TAG_W-1:0]          fill_tag,
  output logic                      ckpt_save,
  output logic                      bogus_retire,
  output logic                      spec_mode,
  output logic                      flush,
  output logic                      restore_valid,
  output logic [AREGS*PREG_W-1:0]   restore_map,
  output logic [BHR_W-1:0]          restore_bhr,
  output logic [RAS_DEPTH*PC_W-1:0] restore_ras,
  output logic                      redirect_valid,
  output logic [PC_W-1:0]           redirect_pc
);
  localparam int MAP_W = AREGS * PREG_W;

  logic             rst_meta_n, rst_sync_n;
  logic [TAG_W-1:0] saved_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ra_fsm #(.TAG_W(TAG_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .head_valid     (head_valid),
    .head_long_miss (head_long_miss),
    .fill_valid     (fill_valid),
    .fill_tag       (fill_tag),
    .held_tag       (saved_tag),
    .enter_o        (ckpt_save),
    .bogus_o        (bogus_retire),
    .spec_o         (spec_mode),
    .flush_o        (flush),
    .restore_o      (restore_valid),
    .redirect_o     (redirect_valid)
  );

  ra_hold_reg #(.W(MAP_W)) u_map (
    .clk(clk), .load(ckpt_save), .d(cur_map), .q(restore_map));
  ra_hold_reg #(.W(BHR_W)) u_bhr (
    .clk(clk), .load(ckpt_save), .d(cur_bhr), .q(restore_bhr));
  ra_hold_reg #(.W(PC_W)) u_pc (
    .clk(clk), .load(ckpt_save), .d(head_pc), .q(redirect_pc));
  ra_hold_reg #(.W(TAG_W)) u_tag (
    .clk(clk), .load(ckpt_save), .d(head_tag), .q(saved_tag));

  for (genvar s = 0; s < RAS_DEPTH; s++) begin : g_ras_slot
    ra_hold_reg #(.W(PC_W)) u_slot (
      .clk  (clk),
      .load (ckpt_save),
      .d    (cur_ras[s*PC_W +: PC_W]),
      .q    (restore_ras[s*PC_W +: PC_W])
    );
  end

  assert_enter_spec_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ckpt_save |=> spec_mode);
  assert_ckpt_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (spec_mode && $past(spec_mode)) |->
      ($stable(redirect_pc) && $stable(saved_tag) && $stable(restore_bhr)));
  assert_single_save_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ckpt_save |=> !ckpt_save);
endmodule

// File: tb/sim_ra_mode_ctrl.sv
module sim_ra_mode_ctrl;
  localparam int AREGS = 8, PREG_W = 5, BHR_W = 12, RAS_DEPTH = 4, PC_W = 16, TAG_W = 4;
  localparam int MAP_W = AREGS * PREG_W;
  localparam int RAS_W = RAS_DEPTH * PC_W;
  localparam int NTAG  = 1 << TAG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic head_valid = 1'b0, head_long_miss = 1'b0;
  logic [PC_W-1:0]  head_pc = '0;
  logic [TAG_W-1:0] head_tag = '0;
  logic [MAP_W-1:0] cur_map = '0;
  logic [BHR_W-1:0] cur_bhr = '0;
  logic [RAS_W-1:0] cur_ras = '0;
  logic fill_valid = 1'b0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic ckpt_save, bogus_retire, spec_mode, flush, restore_valid, redirect_valid;
  logic [MAP_W-1:0] restore_map;
  logic [BHR_W-1:0] restore_bhr;
  logic [RAS_W-1:0] restore_ras;
  logic [PC_W-1:0]  redirect_pc;

  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ra_mode_ctrl #(.AREGS(AREGS), .PREG_W(PREG_W), .BHR_W(BHR_W),
                 .RAS_DEPTH(RAS_DEPTH), .PC_W(PC_W), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_long_miss(head_long_miss),
    .head_pc(head_pc), .head_tag(head_tag), .cur_map(cur_map), .cur_bhr(cur_bhr),
    .cur_ras(cur_ras), .fill_valid(fill_valid), .fill_tag(fill_tag),
    .ckpt_save(ckpt_save), .bogus_retire(bogus_retire), .spec_mode(spec_mode),
    .flush(flush), .restore_valid(restore_valid), .restore_map(restore_map),
    .restore_bhr(restore_bhr), .restore_ras(restore_ras),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    head_valid = 1'b0; head_long_miss = 1'b0; fill_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1'b1;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [PC_W-1:0]  e_pc;
    logic [TAG_W-1:0] e_tag;
    logic [MAP_W-1:0] e_map;
    logic [BHR_W-1:0] e_bhr;
    logic [RAS_W-1:0] e_ras;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    // R10: reset state
    chk(!spec_mode && !ckpt_save && !flush && !restore_valid && !redirect_valid && !bogus_retire,
        "R10", {spec_mode, ckpt_save, flush, restore_valid, redirect_valid, bogus_retire}, 0);
    // R1: miss flag without a valid head does nothing
    head_long_miss = 1'b1; head_valid = 1'b0; #1;
    chk(!ckpt_save, "R1", ckpt_save, 0);
    step();
    chk(!spec_mode, "R1", spec_mode, 0);
    // R7: completion in normal mode ignored
    idle(); fill_valid = 1'b1; fill_tag = 4'h3; step();
    fill_valid = 1'b0; #1;
    chk(!spec_mode && !flush, "R7", spec_mode, 0);
    step();
    chk(!spec_mode && !flush, "R7", flush, 0);

    for (int e = 0; e < 2 * NTAG; e++) begin
      e_tag = TAG_W'(e % NTAG);
      e_pc  = PC_W'(e * 16'h1357 + 16'h0101);
      e_map = MAP_W'(64'(e) * 64'h0123_4567_89AB + 64'd7);
      e_bhr = BHR_W'((e * 12'h2C5) ^ 12'hA5A);
      e_ras = RAS_W'(64'(e) * 64'h0F1E_2D3C_4B5A_6978 + 64'h11);
      // entry cycle
      idle();
      head_valid = 1'b1; head_long_miss = 1'b1; head_pc = e_pc; head_tag = e_tag;
      cur_map = e_map; cur_bhr = e_bhr; cur_ras = e_ras; #1;
      chk(ckpt_save, "R1", ckpt_save, 1);
      chk(bogus_retire, "R4", bogus_retire, 1);
      step();
      // runahead: new head miss ignored as entry, retired bogus
      head_pc = ~e_pc; head_tag = e_tag + 4'd1;
      cur_map = ~e_map; cur_bhr = ~e_bhr; cur_ras = ~e_ras; #1;
      chk(spec_mode, "R5", spec_mode, 1);
      chk(bogus_retire && !ckpt_save, "R6", {bogus_retire, ckpt_save}, 2'b10);
      step();
      idle();
      // every other tag must not end runahead
      for (int t = 1; t < NTAG; t++) begin
        fill_valid = 1'b1; fill_tag = e_tag + TAG_W'(t);
        step();
        chk(spec_mode && !flush, "R7", {spec_mode, flush}, 2'b10);
      end
      // matching completion, optionally with a dependent miss at the head
      fill_valid = 1'b1; fill_tag = e_tag;
      if (e % 2 == 1) begin
        head_valid = 1'b1; head_long_miss = 1'b1;
      end
      #1;
      chk(bogus_retire == (e % 2 == 1), "R6", bogus_retire, 64'(e % 2));
      chk(!flush, "R8", flush, 0);
      step();
      // restore cycle, with an entry attempt
      fill_valid = 1'b0;
      head_valid = 1'b1; head_long_miss = 1'b1; head_pc = 16'hFFFF; head_tag = e_tag;
      #1;
      chk(flush && restore_valid && !redirect_valid, "R8",
          {flush, restore_valid, redirect_valid}, 3'b110);
      chk(spec_mode, "R5", spec_mode, 1);
      chk(!ckpt_save, "R9", ckpt_save, 0);
      chk(restore_map == e_map, "R2", restore_map, e_map);
      chk(restore_bhr == e_bhr, "R2", restore_bhr, e_bhr);
      chk(restore_ras == e_ras, "R2", restore_ras, e_ras);
      step();
      idle(); #1;
      chk(redirect_valid && !flush && !spec_mode, "R8",
          {redirect_valid, flush, spec_mode}, 3'b100);
      chk(redirect_pc == e_pc, "R3", redirect_pc, e_pc);
      chk(redirect_pc == e_pc, "R9", redirect_pc, e_pc);
      step();
      chk(!redirect_valid && !spec_mode, "R8", {redirect_valid, spec_mode}, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule